// File: doc/BRIEF.md
# Three-Lane 7:1 Serial Link Transmitter

This block turns a stream of 21-bit parallel words into three serial data lanes and one forwarded clock lane. Words arrive in a slow word-rate clock domain; a second clock running exactly seven times faster, with rising edges aligned to the slow clock, times the serial bits. Each slow period, every data lane sends seven bits, and the clock lane sends a fixed seven-slot mark. A receiver uses this mark to find where each word starts.

The word input is a valid/ready stream. A word moves on a slow-clock rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the link is live. While `in_ready` is low the source must hold its word, and nothing is taken. There is no storage: a live link consumes one word per slow period. If no word is offered, the data lanes send an all-zero word and the clock lane keeps running.

An active-low powerdown input shuts the link. While the link is shut, `out_en` is low and every serial output is driven to 0, so a pad ring can switch its drivers to high impedance. When powerdown is released, the link waits a settle interval of `SETTLE_CYC` slow-clock edges before it goes live. This interval gives an external PLL time to lock. Each time powerdown is released, the full interval starts over. All inputs are synchronous to the slow clock.

Top module: `stx_link_tx`

## Requirements
- R1: After reset, `out_en`, `ser_data`, `ser_clk`, `in_ready` and `locked` are all 0.
- R2: After `pd_n` goes high, `locked` and `in_ready` rise on the `SETTLE_CYC`-th slow rising edge that samples `pd_n` high, and not before. Until then `out_en` and all serial outputs stay 0.
- R3: A word is taken only on a slow edge where `in_valid` and `in_ready` are both high, and `in_ready` always equals `locked`. A word held on the input across the edge where `locked` rises is not taken on that edge, so that period sends an all-zero word.
- R4: Data lane k (`ser_data[k]`) carries word bits [7k+6:7k] and sends bit 7k in slot 0, then bit 7k+i in slot i.
- R5: For a word taken on slow edge P, slot 0 is on the outputs from the first bit-clock edge after P. Each later slot follows one bit-clock edge later, giving seven slots per slow period.
- R6: While `out_en` is high, `ser_clk` sends 1,1,0,0,0,1,1 in slots 0 to 6 of every period.
- R7: In a period whose slow edge took no word, all data lanes send 0, and `ser_clk` keeps its pattern.
- R8: `pd_n` low forces `out_en`, `ser_data` and `ser_clk` to 0 from the next bit-clock edge. `locked` and `in_ready` fall on the next slow edge.
- R9: Releasing `pd_n` again restarts the full settle count from zero. After that, data flows as in R2 to R5.
- R10: Words taken on consecutive slow edges go out in consecutive periods, with no gap slot between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_px | input | 1 | Slow word-rate clock |
| clk_bit | input | 1 | Bit clock at 7x `clk_px`, rising edges aligned |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| pd_n | input | 1 | Active-low powerdown |
| in_valid | input | 1 | Word stream valid |
| in_ready | output | 1 | Word stream ready, high while live |
| in_data | input | 21 | Parallel word |
| ser_data | output | 3 | Serial data lanes, bit-clock registered |
| ser_clk | output | 1 | Forwarded clock lane, bit-clock registered |
| out_en | output | 1 | Pad drive enable; low means high impedance |
| locked | output | 1 | Settle interval done, slow-clock registered |

## Verification
The end of the settle count and the stream handshake can land on the same slow edge. The bench provokes this by raising `pd_n` while a nonzero word is already held valid on the input, so the word is waiting when the link goes live. The bench then checks that the period starting at the edge where `locked` rises carries all zeros, with a correct clock mark. It also checks that the held word appears exactly one period later. A second overlap drops `pd_n` in the middle of a word while it is shifting out, and the bench checks that the lanes go silent on the next bit edge instead of finishing the word.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    PWR_OFF    = 2'd0,
    PWR_SETTLE = 2'd1,
    PWR_LIVE   = 2'd2
  } pwr_state_e;

  // Forwarded clock mark: high in the first two and last two slots.
  function automatic logic [31:0] clk_mark(input int unsigned ratio);
    logic [31:0] m;
    m = '0;
    for (int unsigned s = 0; s < ratio; s++) begin
      if (s < 2 || s + 2 >= ratio) m[s] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/stx_settle.sv
module stx_settle
  import stx_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 850000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  output logic live
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  pwr_state_e    st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PWR_OFF;
      cnt <= '0;
    end else if (!pd_n) begin
      st  <= PWR_OFF;
      cnt <= '0;
    end else begin
      case (st)
        PWR_OFF: begin
          if (SETTLE_CYC <= 1) begin
            st  <= PWR_LIVE;
            cnt <= '0;
          end else begin
            st  <= PWR_SETTLE;
            cnt <= CW'(1);
          end
        end
        PWR_SETTLE: begin
          if (cnt == LAST) st <= PWR_LIVE;
          else cnt <= cnt + 1'b1;
        end
        PWR_LIVE: st <= PWR_LIVE;
        default: begin
          st  <= PWR_OFF;
          cnt <= '0;
        end
      endcase
    end
  end

  assign live = (st == PWR_LIVE);
endmodule

// File: rtl/stx_capture.sv
module stx_capture #(
  parameter int unsigned WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic [WORD_W-1:0] word_q,
  output logic              tgl
);
  assign in_ready = live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      tgl    <= 1'b0;
    end else begin
      word_q <= (in_valid && live) ? in_data : '0;
      tgl    <= ~tgl;
    end
  end
endmodule

// File: rtl/stx_lane_ser.sv
module stx_lane_ser #(
  parameter int unsigned RATIO = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             en,
  input  logic [RATIO-1:0] par,
  output logic             ser
);
  logic [RATIO-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      ser <= 1'b0;
    end else begin
      if (load) sh <= par >> 1;
      else      sh <= sh >> 1;
      if (!en)       ser <= 1'b0;
      else if (load) ser <= par[0];
      else           ser <= sh[0];
    end
  end
endmodule

// File: rtl/stx_link_tx.sv
module stx_link_tx #(
  parameter int unsigned LANES      = 3,
  parameter int unsigned RATIO      = 7,
  parameter int unsigned SETTLE_CYC = 850000
) (
  input  logic                   clk_px,
  input  logic                   clk_bit,
  input  logic                   rst_n,
  input  logic                   pd_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*RATIO-1:0] in_data,
  output logic [LANES-1:0]       ser_data,
  output logic                   ser_clk,
  output logic                   out_en,
  output logic                   locked
);
  localparam int unsigned WORD_W = LANES * RATIO;
  localparam logic [31:0] MARK_W = stx_pkg::clk_mark(RATIO);

  logic              live;
  logic              tgl;
  logic              tgl_seen;
  logic              load;
  logic              drive;
  logic [WORD_W-1:0] word_q;

  stx_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk   (clk_px),
    .rst_n (rst_n),
    .pd_n  (pd_n),
    .live  (live)
  );

  stx_capture #(.WORD_W(WORD_W)) u_cap (
    .clk      (clk_px),
    .rst_n    (rst_n),
    .live     (live),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .word_q   (word_q),
    .tgl      (tgl)
  );

  assign locked = live;
  assign drive  = pd_n & live;
  assign load   = tgl ^ tgl_seen;

  // The toggle flips on each slow edge; the first bit edge that sees it begins slot 0.
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      tgl_seen <= 1'b0;
      out_en   <= 1'b0;
    end else begin
      tgl_seen <= tgl;
      out_en   <= drive;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    stx_lane_ser #(.RATIO(RATIO)) u_ser (
      .clk   (clk_bit),
      .rst_n (rst_n),
      .load  (load),
      .en    (drive),
      .par   (word_q[k*RATIO +: RATIO]),
      .ser   (ser_data[k])
    );
  end

  stx_lane_ser #(.RATIO(RATIO)) u_clk_lane (
    .clk   (clk_bit),
    .rst_n (rst_n),
    .load  (load),
    .en    (drive),
    .par   (MARK_W[RATIO-1:0]),
    .ser   (ser_clk)
  );
endmodule

// File: rtl/stx_link_tx_chk.sv
module stx_link_tx_chk #(
  parameter int unsigned LANES      = 3,
  parameter int unsigned SETTLE_CYC = 850000
) (
  input logic             clk_px,
  input logic             clk_bit,
  input logic             rst_n,
  input logic             pd_n,
  input logic             out_en,
  input logic             ser_clk,
  input logic [LANES-1:0] ser_data,
  input logic             locked
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(SETTLE_CYC);

  logic [CW-1:0] up_cnt;

  always_ff @(posedge clk_px or negedge rst_n) begin
    if (!rst_n)            up_cnt <= '0;
    else if (!pd_n)        up_cnt <= '0;
    else if (up_cnt < SAT) up_cnt <= up_cnt + 1'b1;
  end

  p_off_silent_r8: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !out_en |-> (ser_data == '0 && !ser_clk));

  p_pd_quiet_r8: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !pd_n |=> !out_en);

  p_pd_unlock_r8: assert property (@(posedge clk_px) disable iff (!rst_n)
    !pd_n |=> !locked);

  p_lock_needs_pd_r2: assert property (@(posedge clk_px) disable iff (!rst_n)
    locked |-> $past(pd_n));

  p_settle_len_r9: assert property (@(posedge clk_px) disable iff (!rst_n)
    $rose(locked) |-> (up_cnt >= SAT));

  p_mark_high_pair_r6: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (out_en && $past(out_en) && $rose(ser_clk)) |=> (ser_clk || !out_en));

  p_mark_low_pair_r6: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (out_en && $past(out_en) && $fell(ser_clk)) |=> (!ser_clk));
endmodule

bind stx_link_tx stx_link_tx_chk #(.LANES(LANES), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_px   (clk_px),
  .clk_bit  (clk_bit),
  .rst_n    (rst_n),
  .pd_n     (pd_n),
  .out_en   (out_en),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .locked   (locked)
);

// File: tb/sim_stx_link_tx.sv
`timescale 1ns/1ps
module sim_stx_link_tx;
  localparam int LANES  = 3;
  localparam int RATIO  = 7;
  localparam int SETTLE = 6;
  localparam int W      = LANES * RATIO;
  localparam logic [RATIO-1:0] MARK = 7'b1100011; // slots 0..6 = 1,1,0,0,0,1,1

  logic clk_px = 1'b0, clk_bit = 1'b0, rst_n = 1'b0, pd_n = 1'b0;
  logic in_valid = 1'b0, in_ready, ser_clk, out_en, locked;
  logic [W-1:0] in_data = '0;
  logic [LANES-1:0] ser_data;
  int n_chk = 0, n_fail = 0;

  stx_link_tx #(.LANES(LANES), .RATIO(RATIO), .SETTLE_CYC(SETTLE)) u0 (
    .clk_px(clk_px), .clk_bit(clk_bit), .rst_n(rst_n), .pd_n(pd_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ser_data(ser_data), .ser_clk(ser_clk), .out_en(out_en), .locked(locked));

  // 125 MHz bit clock; slow clock rises with every seventh bit-clock rise.
  initial forever #4 clk_bit = ~clk_bit;
  initial begin
    #4;
    forever begin
      clk_px = 1'b1; #28;
      clk_px = 1'b0; #28;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Called at the slot-0 sample point; returns at the next one. Drives the next word after slot 2.
  task automatic check_frame(input logic [W-1:0] w, input logic nv,
                             input logic [W-1:0] nd, input string rq);
    logic [W-1:0] got_w = '0;
    logic [RATIO-1:0] got_c = '0;
    bit en_ok = 1'b1;
    for (int i = 0; i < RATIO; i++) begin
      for (int k = 0; k < LANES; k++) got_w[k*RATIO + i] = ser_data[k];
      got_c[i] = ser_clk;
      if (!out_en) en_ok = 1'b0;
      if (i == 2) begin
        in_valid = nv;
        in_data  = nd;
      end
      #8;
    end
    chk(en_ok, rq, "out_en during frame", 64'(en_ok), 64'd1);
    chk(got_w == w, rq, "lane bits", 64'(got_w), 64'(w));
    chk(got_c == MARK, "R6", "clock lane mark", 64'(got_c), 64'(MARK));
  endtask

  task automatic t_reset();
    @(negedge clk_px);
    rst_n = 1'b1;
    #4;
    chk(out_en == 0 && ser_data == 0 && ser_clk == 0, "R1", "serial outputs",
        {ser_data, ser_clk, out_en}, 64'd0);
    chk(in_ready == 0 && locked == 0, "R1", "ready/locked", {in_ready, locked}, 64'd0);
  endtask

  // R2 and R3: a word is held valid while settling; lock and handshake share an edge.
  task automatic t_settle_handshake();
    @(negedge clk_px);
    pd_n = 1'b1; in_valid = 1'b1; in_data = 21'h15A3C7;
    repeat (SETTLE - 1) @(posedge clk_px);
    #2;
    chk(locked == 0 && in_ready == 0, "R2", "not live before count",
        {locked, in_ready}, 64'd0);
    chk(out_en == 0 && ser_data == 0, "R2", "quiet while settling",
        {ser_data, out_en}, 64'd0);
    @(posedge clk_px); #2;
    chk(locked == 1 && in_ready == 1, "R2", "live at count", {locked, in_ready}, 64'd3);
    #10;
    check_frame('0, 1'b1, 21'h15A3C7, "R3");
    check_frame(21'h15A3C7, 1'b1, 21'h0ABCDE, "R3");
  endtask

  // R4/R5: a word with distinct lanes; R10: back-to-back words without gaps.
  task automatic t_stream();
    check_frame(21'h0ABCDE, 1'b1, 21'h00007F, "R4");
    check_frame(21'h00007F, 1'b1, 21'h1FC000, "R4");
    check_frame(21'h1FC000, 1'b1, 21'h000001, "R5");
    check_frame(21'h000001, 1'b1, 21'h155555, "R10");
    check_frame(21'h155555, 1'b1, 21'h0AAAAA, "R10");
  endtask

  // R7: no valid word, so zeros go out with the clock mark intact.
  task automatic t_idle();
    check_frame(21'h0AAAAA, 1'b0, 21'h1FFFFF, "R10");
    check_frame('0, 1'b1, 21'h12345F, "R7");
    check_frame(21'h12345F, 1'b1, 21'h1FFFFF, "R7");
  endtask

  // R8: powerdown mid-word. Entry is at a slot-0 sample point.
  task automatic t_powerdown();
    #16;
    pd_n = 1'b0;
    #12;
    chk(out_en == 0 && ser_data == 0 && ser_clk == 0, "R8", "silent next bit edge",
        {ser_data, ser_clk, out_en}, 64'd0);
    @(posedge clk_px); #2;
    chk(locked == 0 && in_ready == 0, "R8", "unlock next slow edge",
        {locked, in_ready}, 64'd0);
    repeat (3) @(posedge clk_px);
    #2;
    chk(out_en == 0 && ser_data == 0, "R8", "stays silent", {ser_data, out_en}, 64'd0);
  endtask

  // R9: release again; full settle count restarts, then data flows.
  task automatic t_relock();
    @(negedge clk_px);
    pd_n = 1'b1; in_valid = 1'b1; in_data = 21'h0F0F0F;
    repeat (SETTLE - 1) @(posedge clk_px);
    #2;
    chk(locked == 0, "R9", "not live before full count", 64'(locked), 64'd0);
    @(posedge clk_px); #2;
    chk(locked == 1, "R9", "live after full count", 64'(locked), 64'd1);
    #10;
    check_frame('0, 1'b1, 21'h0F0F0F, "R9");
    check_frame(21'h0F0F0F, 1'b0, '0, "R9");
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_settle_handshake();
    t_stream();
    t_idle();
    t_powerdown();
    t_relock();
    report();
    $finish;
  end
endmodule